// File: doc/BRIEF.md
# Transmit Frame Builder with Frame Check Sequence

This block turns a payload into a complete transmit frame for a 2.4 GHz low-rate PHY. It sends four zero bytes of preamble, a start-of-frame delimiter of 0xA7 and a length byte. The payload follows, then a two-byte CRC that the block computes itself. The caller never supplies or sees the CRC. The payload comes from one of two places. In buffered mode the caller fills an internal payload store through a valid/ready load port and then issues a start command. In streaming mode the block asks for each payload byte with a one-cycle request pulse and takes it from a valid/ready stream port.

The frame leaves on a valid/ready byte port through one output register. Back-pressure rules: while `out_valid` is high and `out_ready` is low, the byte and its last marker are held unchanged. A byte is transferred only in a cycle where both are high. The load and stream ports follow the same rule from the other side. A byte is taken only when valid and ready are both high in the same cycle. The source may hold valid for any number of cycles.

A separate receive checker runs the same CRC over an incoming payload and its two appended check bytes. It then reports whether the frame arrived intact. Spreading, modulation and RF are handled elsewhere.

Top module: `pkt_framer_fcs`

## Requirements
- R1: After reset `out_valid`, `st_req`, `done`, `len_err`, `underrun` and `rx_done` are low, and `ld_ready` is high.
- R2: Every accepted frame begins with four 0x00 bytes, then 0xA7, then one byte equal to the payload length plus 2.
- R3: In buffered mode the payload bytes go out in the order they were loaded. The first byte loaded is sent first. The store holds up to 125 bytes.
- R4: After the payload come two CRC bytes, low byte first. The CRC is CRC-16 with polynomial x^16+x^12+x^5+1, initial value 0 and no final inversion, with data bits taken LSB first (reflected constant 0x8408). A frame is therefore payload length + 8 bytes long.
- R5: `done` pulses for exactly one cycle per completed frame. It is high in the first cycle that the final CRC byte is presented, and `out_last` is high with that byte only.
- R6: A start with length 0 or greater than 125 produces a one-cycle `len_err` pulse in the next cycle. No byte is sent and the block stays idle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R8: In streaming mode `st_req` pulses once for each payload byte the block wants, so exactly length pulses per frame. `st_ready` is high only while the block is waiting for a payload byte and the output register can take it.
- R9: If a wanted streaming byte is not supplied within 16 cycles in which the block could take it, `underrun` pulses once. The frame ends there with no CRC bytes, no `out_last` and no `done`, and the next start is served normally.
- R10: On `rx_valid` with `rx_last`, `rx_done` pulses in the next cycle. `rx_crc_ok` is then high if and only if the CRC run over all bytes since the previous last byte (payload then low and high check byte) leaves a zero remainder. The flag holds until the next `rx_done`.
- R11: `ld_ready` is low while a frame is being sent. Once a buffered-mode frame completes, the next load writes store position 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_mode | input | 1 | Payload source sampled at start: 1 streaming, 0 buffered |
| start | input | 1 | Start command (one cycle) |
| start_len | input | 7 | Payload length for the start command |
| ld_valid | input | 1 | Load byte valid |
| ld_data | input | 8 | Load byte |
| ld_ready | output | 1 | Store can accept a load byte |
| st_valid | input | 1 | Streaming byte valid |
| st_data | input | 8 | Streaming byte |
| st_ready | output | 1 | Block is taking a streaming byte |
| st_req | output | 1 | Request pulse for the next streaming byte |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Marks the final CRC byte |
| out_ready | input | 1 | Downstream accepts the frame byte |
| done | output | 1 | Frame completion pulse |
| len_err | output | 1 | Rejected-length pulse |
| underrun | output | 1 | Streaming underrun pulse (frame aborted) |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte is the final check byte |
| rx_done | output | 1 | Receive check complete pulse |
| rx_crc_ok | output | 1 | Last received frame had a correct CRC |

## Verification
The bench drives the edges of the length range: one byte, 125 bytes, and the rejected lengths 0, 126 and 127. A design with an off-by-one limit would either send a frame it should refuse or raise `len_err` on a legal length. Random output stalls check that a held byte never changes or gets dropped, which would show up as a corrupted frame or a wrong CRC. In streaming mode the source is starved partway through a frame. A wrong design would then send CRC bytes, assert `done`, or hang instead of pulsing `underrun` once. The receive checker sees both intact and single-byte-corrupted frames, so a checker that looks at the wrong remainder or check-byte order would flag the wrong one.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_SFD, S_LEN, S_PAY, S_FLO, S_FHI
  } fr_state_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/fr_buf.sv
module fr_buf #(
  parameter int DEPTH = 125,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          full
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;

  assign full    = (wr_ptr == AW'(DEPTH));
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
    end else if (wr_en && !full) begin
      mem[wr_ptr] <= wr_data;
      wr_ptr      <= wr_ptr + 1'b1;
    end
  end

  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> $stable(wr_ptr));
endmodule

// File: rtl/fr_rx_check.sv
module fr_rx_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  output logic       rx_done,
  output logic       rx_crc_ok
);
  import fr_pkg::*;
  logic [15:0] crc_q;
  logic [15:0] crc_nx;

  assign crc_nx = crc16_byte(crc_q, rx_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q     <= '0;
      rx_done   <= 1'b0;
      rx_crc_ok <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rx_valid) begin
        if (rx_last) begin
          crc_q     <= '0;
          rx_done   <= 1'b1;
          rx_crc_ok <= (crc_nx == 16'h0000);
        end else begin
          crc_q <= crc_nx;
        end
      end
    end
  end

  a_r10_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rx_valid && rx_last));
  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_crc_ok));
endmodule

// File: rtl/pkt_framer_fcs.sv
module pkt_framer_fcs #(
  parameter int MAX_PAY = 125,
  parameter int PRE_LEN = 4,
  parameter logic [7:0] SFD_BYTE = 8'hA7,
  parameter int TMO     = 16,
  localparam int LW = $clog2(MAX_PAY + 1),
  localparam int WW = $clog2(TMO) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stream_mode,
  input  logic          start,
  input  logic [LW-1:0] start_len,
  input  logic          ld_valid,
  input  logic [7:0]    ld_data,
  output logic          ld_ready,
  input  logic          st_valid,
  input  logic [7:0]    st_data,
  output logic          st_ready,
  output logic          st_req,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          done,
  output logic          len_err,
  output logic          underrun,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_done,
  output logic          rx_crc_ok
);
  import fr_pkg::*;

  fr_state_e     state;
  logic [LW-1:0] cnt, len_q;
  logic          mode_q;
  logic [15:0]   crc_q;
  logic [WW-1:0] wcnt;
  logic          can_load, emit, elast, pay_last, buf_full, buf_clr;
  logic [7:0]    ed, rd_data;

  fr_buf #(.DEPTH(MAX_PAY)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .wr_en(ld_valid && ld_ready), .wr_data(ld_data),
    .rd_addr(cnt), .rd_data(rd_data), .full(buf_full)
  );

  fr_rx_check u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_done(rx_done), .rx_crc_ok(rx_crc_ok)
  );

  assign can_load = !out_valid || out_ready;
  assign st_ready = (state == S_PAY) && mode_q && can_load;
  assign ld_ready = (state == S_IDLE) && !buf_full;
  assign pay_last = (cnt == len_q - 1'b1);
  assign buf_clr  = (state == S_FHI) && can_load && !mode_q;

  always_comb begin
    emit  = 1'b0;
    ed    = 8'h00;
    elast = 1'b0;
    unique case (state)
      S_PRE: emit = can_load;
      S_SFD: begin emit = can_load; ed = SFD_BYTE; end
      S_LEN: begin emit = can_load; ed = 8'(len_q) + 8'd2; end
      S_PAY: begin
        if (mode_q) begin emit = st_valid && st_ready; ed = st_data; end
        else        begin emit = can_load;             ed = rd_data; end
      end
      S_FLO: begin emit = can_load; ed = crc_q[7:0]; end
      S_FHI: begin emit = can_load; ed = crc_q[15:8]; elast = 1'b1; end
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      len_q     <= '0;
      mode_q    <= 1'b0;
      crc_q     <= '0;
      wcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      len_err   <= 1'b0;
      underrun  <= 1'b0;
      st_req    <= 1'b0;
    end else begin
      done     <= 1'b0;
      len_err  <= 1'b0;
      underrun <= 1'b0;
      st_req   <= 1'b0;
      if (can_load) begin
        out_valid <= emit;
        out_data  <= ed;
        out_last  <= elast && emit;
      end
      unique case (state)
        S_IDLE: if (start) begin
          if (start_len == '0 || start_len > LW'(MAX_PAY)) begin
            len_err <= 1'b1;
          end else begin
            state  <= S_PRE;
            cnt    <= '0;
            len_q  <= start_len;
            mode_q <= stream_mode;
            crc_q  <= '0;
          end
        end
        S_PRE: if (can_load) begin
          cnt <= cnt + 1'b1;
          if (cnt == LW'(PRE_LEN - 1)) state <= S_SFD;
        end
        S_SFD: if (can_load) state <= S_LEN;
        S_LEN: if (can_load) begin
          state  <= S_PAY;
          cnt    <= '0;
          wcnt   <= '0;
          st_req <= mode_q;
        end
        S_PAY: begin
          if (emit) begin
            crc_q <= crc16_byte(crc_q, ed);
            cnt   <= cnt + 1'b1;
            wcnt  <= '0;
            if (pay_last) state  <= S_FLO;
            else          st_req <= mode_q;
          end else if (mode_q && can_load) begin
            if (wcnt == WW'(TMO - 1)) begin
              underrun <= 1'b1;
              state    <= S_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        S_FLO: if (can_load) state <= S_FHI;
        S_FHI: if (can_load) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r5_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_last);
  a_r6_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> state == S_IDLE);
  a_r9_abort_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> state == S_IDLE && !out_last);
  a_r8_ready_only_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> mode_q && state == S_PAY);
  a_r11_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |-> !ld_ready);
  a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |-> len_q != '0 && len_q <= LW'(MAX_PAY));
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, len_err, underrun}));
endmodule

// File: tb/tb_pkt_framer_fcs.sv
module tb_pkt_framer_fcs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stream_mode = 1'b0, start = 1'b0;
  logic [6:0] start_len = '0;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_data = '0;
  logic       ld_ready;
  logic       st_valid = 1'b0;
  logic [7:0] st_data = '0;
  logic       st_ready, st_req;
  logic       out_valid, out_last, out_ready = 1'b1;
  logic [7:0] out_data;
  logic       done, len_err, underrun;
  logic       rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_done, rx_crc_ok;

  int n_tests = 0, n_fail = 0;
  logic [7:0] pay [128];
  logic [7:0] got [256];

  always #10 clk = ~clk;

  pkt_framer_fcs dut (
    .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode), .start(start),
    .start_len(start_len), .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready), .st_req(st_req),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .done(done), .len_err(len_err), .underrun(underrun),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_done(rx_done), .rx_crc_ok(rx_crc_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] r = 16'h0000;
    for (int i = 0; i < len; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ pay[i][b];
        r  = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'h8408;
      end
    end
    return r;
  endfunction

  task automatic run_frame(input bit strm, input int len, input int rdy_pct, input int stop_at);
    int ngot = 0, sidx = 0, nreq = 0, ndone = 0, nund = 0, wt = 0;
    bit fin = 0, prev_hold = 0, ld_seen = 0;
    logic [7:0] prev_data = '0;
    logic [15:0] c;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    if (!strm) begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk); ld_valid = 1'b1; ld_data = pay[i];
        #1 chk(ld_ready, "R3 load accepted", int'(ld_ready), 1);
      end
      @(negedge clk); ld_valid = 1'b0;
    end
    @(negedge clk); start = 1'b1; start_len = 7'(len); stream_mode = strm;
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      @(negedge clk); start = 1'b0;
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R7 held byte", int'(out_data), int'(prev_data));
      if (st_req) nreq++;
      if (underrun) nund++;
      if (done) begin
        ndone++;
        chk(out_valid && out_last, "R5 done with last", int'(out_last), 1);
      end
      if (cyc == 3) begin
        ld_seen = 1;
        chk(!ld_ready, "R11 load blocked while busy", int'(ld_ready), 0);
      end
      out_ready = ($urandom % 100) < rdy_pct;
      if (strm && sidx < len && !(stop_at >= 0 && sidx >= stop_at)) begin
        st_valid = (wt >= 6) || ($urandom % 2 == 0);
        st_data  = pay[sidx];
      end else begin
        st_valid = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        got[ngot] = out_data;
        ngot++;
        if (out_last) fin = 1;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (st_valid && st_ready) begin sidx++; wt = 0; end
      else if (st_ready) wt++;
      if (nund > 0 && !out_valid) fin = 1;
    end
    st_valid = 1'b0; out_ready = 1'b1;
    chk(fin, "R5 frame finished", int'(fin), 1);
    chk(ld_seen, "R11 busy observed", int'(ld_seen), 1);
    for (int i = 0; i < 4; i++)
      chk(got[i] == 8'h00, "R2 preamble", int'(got[i]), 0);
    chk(got[4] == 8'hA7, "R2 delimiter", int'(got[4]), 'hA7);
    chk(got[5] == 8'(len + 2), "R2 length byte", int'(got[5]), len + 2);
    if (stop_at < 0) begin
      c = ref_crc(len);
      chk(ngot == len + 8, "R4 frame size", ngot, len + 8);
      for (int i = 0; i < len; i++)
        if (got[6 + i] != pay[i])
          chk(0, strm ? "R8 stream payload" : "R3 buffered payload", int'(got[6 + i]), int'(pay[i]));
      chk(got[6 + len] == c[7:0], "R4 crc low", int'(got[6 + len]), int'(c[7:0]));
      chk(got[7 + len] == c[15:8], "R4 crc high", int'(got[7 + len]), int'(c[15:8]));
      chk(ndone == 1, "R5 one done", ndone, 1);
      if (strm) chk(nreq == len, "R8 request count", nreq, len);
    end else begin
      chk(nund == 1, "R9 underrun pulse", nund, 1);
      chk(ndone == 0, "R9 no done", ndone, 0);
      chk(ngot == 6 + stop_at, "R9 no crc sent", ngot, 6 + stop_at);
      chk(nreq == stop_at + 1, "R9 requests", nreq, stop_at + 1);
    end
  endtask

  task automatic bad_len(input int len);
    @(negedge clk); start = 1'b1; start_len = 7'(len);
    @(negedge clk); start = 1'b0;
    chk(len_err, "R6 error pulse", int'(len_err), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_valid || len_err) chk(0, "R6 nothing sent", int'(out_valid), 0);
    end
    chk(ld_ready, "R6 still idle", int'(ld_ready), 1);
  endtask

  task automatic rx_frame(input int len, input bit corrupt);
    logic [15:0] c;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    c = ref_crc(len);
    if (corrupt) pay[len / 2] = pay[len / 2] ^ 8'h10;
    for (int i = 0; i < len + 2; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = (i < len) ? pay[i] : (i == len ? c[7:0] : c[15:8]);
      rx_last  = (i == len + 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    chk(rx_done, "R10 done pulse", int'(rx_done), 1);
    chk(rx_crc_ok == !corrupt, "R10 crc flag", int'(rx_crc_ok), int'(!corrupt));
    @(negedge clk);
    chk(!rx_done && rx_crc_ok == !corrupt, "R10 flag held", int'(rx_crc_ok), int'(!corrupt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !st_req && !done && !len_err && !underrun && !rx_done,
        "R1 outputs idle", int'(out_valid), 0);
    chk(ld_ready, "R1 load ready", int'(ld_ready), 1);

    run_frame(0, 1, 100, -1);
    run_frame(0, 125, 70, -1);
    run_frame(0, 17, 50, -1);
    run_frame(1, 1, 100, -1);
    run_frame(1, 40, 60, -1);
    bad_len(0);
    bad_len(126);
    bad_len(127);
    run_frame(1, 10, 100, 4);
    run_frame(1, 5, 100, 0);
    run_frame(0, 9, 80, -1);
    for (int k = 0; k < 6; k++)
      run_frame(k[0], 1 + int'($urandom % 125), 30 + int'($urandom % 70), -1);
    rx_frame(20, 0);
    rx_frame(20, 1);
    rx_frame(1, 0);
    rx_frame(125, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule